// File: doc/BRIEF.md
# SPI Flash Identification Responder

This block sits behind the serial pins of a chip and answers the identification requests that a host controller sends to a serial flash device. It runs on a fast system clock and oversamples chip select, serial clock and the serial data input through a synchronizer. It counts serial clock rising edges from the moment chip select goes low, takes the first eight bits as an instruction, and then shifts the matching identification bytes out on the serial data output, most significant bit first.

Three answering commands are supported. The first is a three-byte identification read: manufacturer, memory type, then capacity. The second is a manufacturer/device read whose byte order is picked by an address byte that follows two dummy bytes. The third is a wake command that answers with a one-byte legacy signature after three dummy bytes. It also clears a power-down flag. A fourth instruction sets that flag. While the flag is set, the two identification reads go unanswered. All ID values, opcodes and dummy counts are parameters.

Top module: `spi_id_responder`

## Requirements
- R1: After reset, `miso_oe` is 0 and `asleep` is 0.
- R2: After opcode 9Fh, slots 8 to 31 carry the manufacturer byte, then the memory-type byte, then the capacity byte, each MSB first. The sequence repeats every 24 slots for as long as chip select stays low. A slot is the interval before a given serial clock rising edge, counted from 0.
- R3: After opcode 90h, slots 8 to 31 are high-impedance: two dummy bytes, then the address byte in slots 24 to 31. From slot 32 the output is as follows. When address bit 0 (the bit in slot 31) is 0, the manufacturer byte comes first and the device byte second. When that bit is 1, the device byte comes first. The two-byte pair repeats every 16 slots.
- R4: After opcode ABh, slots 8 to 31 are high-impedance. From slot 32 the legacy signature byte is sent MSB first, repeating every 8 slots.
- R5: The output enable is 0 during the opcode slots, during the dummy and address slots, for any opcode that is not recognised, and from the cycle after deselection onward.
- R6: Both mode 0 (clock idles low) and mode 3 (clock idles high) work. Input is captured on the rising edge and output changes only after a falling edge.
- R7: Raising chip select aborts the command. The next selection starts again at slot 0 with no state left over.
- R8: Opcode B9h followed by deselection after exactly 8 rising edges sets `asleep`. The same opcode with more than 8 clocks has no effect.
- R9: While `asleep` is 1, opcodes 9Fh and 90h leave the output high-impedance throughout. Opcode ABh is still answered.
- R10: `asleep` clears on the 8th rising edge of opcode ABh, even if chip select rises right after the opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso`; 0 means high-impedance |
| asleep | output | 1 | Power-down flag |

## Verification
The bench builds the block with identification bytes C2h, 31h, 16h, 4Eh and 8Dh. These values are distinct and none reads the same reversed, so a swapped byte order, a wrong byte or a bit-reversed shift shows up as a mismatch. The opcodes, dummy counts and two-stage synchronizer keep their default values. With those defaults, both delayed commands start data at slot 32, the point where the slot counter saturates. Long transfers therefore exercise the cyclic repeat after saturation in both clock modes.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_JEDEC,
        CMD_MFDEV,
        CMD_WAKE,
        CMD_SLEEP
    } cmd_e;

endpackage

// File: rtl/spi_id_sync.sv
module spi_id_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_id_decode.sv
module spi_id_decode
    import spi_id_pkg::*;
#(
    parameter logic [7:0] OP_JEDEC = 8'h9F,
    parameter logic [7:0] OP_MFDEV = 8'h90,
    parameter logic [7:0] OP_WAKE  = 8'hAB,
    parameter logic [7:0] OP_SLEEP = 8'hB9
) (
    input  logic [7:0] opcode,
    input  logic       asleep,
    output cmd_e       cmd
);
    always_comb begin
        if (opcode == OP_WAKE)                   cmd = CMD_WAKE;
        else if (opcode == OP_SLEEP)             cmd = CMD_SLEEP;
        else if (opcode == OP_JEDEC && !asleep)  cmd = CMD_JEDEC;
        else if (opcode == OP_MFDEV && !asleep)  cmd = CMD_MFDEV;
        else                                     cmd = CMD_NONE;
    end
endmodule

// File: rtl/spi_id_stream.sv
module spi_id_stream
    import spi_id_pkg::*;
#(
    parameter logic [7:0] MFR_ID   = 8'hC2,
    parameter logic [7:0] MEM_TYPE = 8'h20,
    parameter logic [7:0] MEM_CAP  = 8'h15,
    parameter logic [7:0] DEV_ID   = 8'h14,
    parameter logic [7:0] SIG_ID   = 8'h14,
    parameter int         POS_W    = 5
) (
    input  cmd_e             cmd,
    input  logic             swap,
    input  logic [POS_W-1:0] pos,
    output logic             bit_o,
    output logic             last
);
    logic [7:0] cur_byte;
    logic [1:0] byte_idx;
    logic [2:0] bit_idx;
    logic [1:0] final_idx;

    assign byte_idx = pos[4:3];
    assign bit_idx  = 3'd7 - pos[2:0];

    always_comb begin
        cur_byte  = 8'h00;
        final_idx = 2'd0;
        case (cmd)
            CMD_JEDEC: begin
                final_idx = 2'd2;
                case (byte_idx)
                    2'd0:    cur_byte = MFR_ID;
                    2'd1:    cur_byte = MEM_TYPE;
                    default: cur_byte = MEM_CAP;
                endcase
            end
            CMD_MFDEV: begin
                final_idx = 2'd1;
                cur_byte  = (byte_idx[0] ^ swap) ? DEV_ID : MFR_ID;
            end
            CMD_WAKE: begin
                final_idx = 2'd0;
                cur_byte  = SIG_ID;
            end
            default: begin
                final_idx = 2'd0;
                cur_byte  = 8'h00;
            end
        endcase
    end

    assign bit_o = cur_byte[bit_idx];
    assign last  = (byte_idx == final_idx) && (pos[2:0] == 3'd7);
endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
    import spi_id_pkg::*;
#(
    parameter logic [7:0] MFR_ID      = 8'hC2,
    parameter logic [7:0] MEM_TYPE    = 8'h20,
    parameter logic [7:0] MEM_CAP     = 8'h15,
    parameter logic [7:0] DEV_ID      = 8'h14,
    parameter logic [7:0] SIG_ID      = 8'h14,
    parameter logic [7:0] OP_JEDEC    = 8'h9F,
    parameter logic [7:0] OP_MFDEV    = 8'h90,
    parameter logic [7:0] OP_WAKE     = 8'hAB,
    parameter logic [7:0] OP_SLEEP    = 8'hB9,
    parameter int         MFDEV_DUMMY = 2,
    parameter int         WAKE_DUMMY  = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe,
    output logic asleep
);
    localparam int OPC_BITS    = 8;
    localparam int JEDEC_START = OPC_BITS;
    localparam int MFDEV_START = OPC_BITS * (MFDEV_DUMMY + 2);
    localparam int WAKE_START  = OPC_BITS * (WAKE_DUMMY + 1);
    localparam int HDR_MAX     = (MFDEV_START > WAKE_START) ? MFDEV_START : WAKE_START;
    localparam int CNT_W       = $clog2(HDR_MAX + 1);
    localparam int POS_W       = 5;

    typedef struct packed {
        logic             cs_prev;
        logic             sck_prev;
        logic [CNT_W-1:0] hdr;
        logic [7:0]       shift;
        cmd_e             cmd;
        logic             swap;
        logic [POS_W-1:0] pos;
        logic             oe;
        logic             dout;
        logic             pd;
    } state_t;

    state_t s_d, s_q;

    // synchronised pins: {cs_n, sck, mosi}
    logic [2:0] pins_s;
    logic       cs_act, sck_s, mosi_s;

    spi_id_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, mosi}),
        .q     (pins_s)
    );

    assign cs_act = ~pins_s[2];
    assign sck_s  = pins_s[1];
    assign mosi_s = pins_s[0];

    logic       sck_rise, sck_fall;
    logic [7:0] shift_in;
    cmd_e       dec_cmd;
    logic       stream_bit, stream_last;
    logic       in_data;

    assign sck_rise = cs_act &  sck_s & ~s_q.sck_prev;
    assign sck_fall = cs_act & ~sck_s &  s_q.sck_prev;
    assign shift_in = {s_q.shift[6:0], mosi_s};

    spi_id_decode #(
        .OP_JEDEC (OP_JEDEC),
        .OP_MFDEV (OP_MFDEV),
        .OP_WAKE  (OP_WAKE),
        .OP_SLEEP (OP_SLEEP)
    ) u_dec (
        .opcode (shift_in),
        .asleep (s_q.pd),
        .cmd    (dec_cmd)
    );

    spi_id_stream #(
        .MFR_ID   (MFR_ID),
        .MEM_TYPE (MEM_TYPE),
        .MEM_CAP  (MEM_CAP),
        .DEV_ID   (DEV_ID),
        .SIG_ID   (SIG_ID),
        .POS_W    (POS_W)
    ) u_stream (
        .cmd   (s_q.cmd),
        .swap  (s_q.swap),
        .pos   (s_q.pos),
        .bit_o (stream_bit),
        .last  (stream_last)
    );

    always_comb begin
        case (s_q.cmd)
            CMD_JEDEC: in_data = (s_q.hdr >= CNT_W'(JEDEC_START));
            CMD_MFDEV: in_data = (s_q.hdr >= CNT_W'(MFDEV_START));
            CMD_WAKE:  in_data = (s_q.hdr >= CNT_W'(WAKE_START));
            default:   in_data = 1'b0;
        endcase
    end

    always_comb begin
        s_d          = s_q;
        s_d.cs_prev  = cs_act;
        s_d.sck_prev = sck_s;
        if (!cs_act) begin
            if (s_q.cs_prev && s_q.cmd == CMD_SLEEP && s_q.hdr == CNT_W'(OPC_BITS))
                s_d.pd = 1'b1;
            s_d.hdr  = '0;
            s_d.cmd  = CMD_NONE;
            s_d.swap = 1'b0;
            s_d.pos  = '0;
            s_d.oe   = 1'b0;
        end else begin
            if (sck_rise) begin
                s_d.shift = shift_in;
                if (s_q.hdr != CNT_W'(HDR_MAX))
                    s_d.hdr = s_q.hdr + 1'b1;
                if (s_q.hdr == CNT_W'(OPC_BITS - 1)) begin
                    s_d.cmd = dec_cmd;
                    if (dec_cmd == CMD_WAKE)
                        s_d.pd = 1'b0;
                end
                if (s_q.cmd == CMD_MFDEV && s_q.hdr == CNT_W'(MFDEV_START - 1))
                    s_d.swap = shift_in[0];
            end
            if (sck_fall && in_data) begin
                s_d.dout = stream_bit;
                s_d.oe   = 1'b1;
                s_d.pos  = stream_last ? '0 : s_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.cmd      <= CMD_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign miso    = s_q.dout;
    assign miso_oe = s_q.oe;
    assign asleep  = s_q.pd;

    // plain views for the bound checker
    logic             chk_cs_prev;
    logic [CNT_W-1:0] chk_hdr;
    assign chk_cs_prev = s_q.cs_prev;
    assign chk_hdr     = s_q.hdr;
endmodule

// File: rtl/spi_id_responder_chk.sv
module spi_id_responder_chk #(
    parameter int HDR_MAX = 32,
    parameter int CNT_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_act,
    input logic             cs_prev,
    input logic             sck_rise,
    input logic             sck_fall,
    input logic [CNT_W-1:0] hdr,
    input logic             miso,
    input logic             miso_oe,
    input logic             asleep
);
    p_oe_off_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso_oe);

    p_oe_data_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> (hdr >= CNT_W'(8)));

    p_miso_fall_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(miso));

    p_sleep_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> ($past(cs_prev) && !$past(cs_act)));

    p_wake_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> ($past(sck_rise) && $past(hdr) == CNT_W'(7)));

    p_hdr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hdr <= CNT_W'(HDR_MAX));
endmodule

bind spi_id_responder spi_id_responder_chk #(
    .HDR_MAX (HDR_MAX),
    .CNT_W   (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .cs_prev  (chk_cs_prev),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .hdr      (chk_hdr),
    .miso     (miso),
    .miso_oe  (miso_oe),
    .asleep   (asleep)
);

// File: tb/spi_id_responder_test.sv
module spi_id_responder_test;
    localparam logic [7:0] T_MFR  = 8'hC2;
    localparam logic [7:0] T_TYPE = 8'h31;
    localparam logic [7:0] T_CAP  = 8'h16;
    localparam logic [7:0] T_DEV  = 8'h4E;
    localparam logic [7:0] T_SIG  = 8'h8D;
    localparam int         HALF   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, miso_oe, asleep;

    int errors = 0;
    int checks = 0;
    bit asleep_m = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_id_responder #(
        .MFR_ID   (T_MFR),
        .MEM_TYPE (T_TYPE),
        .MEM_CAP  (T_CAP),
        .DEV_ID   (T_DEV),
        .SIG_ID   (T_SIG)
    ) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sck     (sck),
        .mosi    (mosi),
        .miso    (miso),
        .miso_oe (miso_oe),
        .asleep  (asleep)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // 2 means high-impedance expected
    function automatic int exp_slot(input logic [7:0] op, input int k,
                                    input bit swp, input bit slp);
        int p;
        logic [7:0] b;
        if (op == 8'h9F && !slp && k >= 8) begin
            p = (k - 8) % 24;
            b = (p / 8 == 0) ? T_MFR : (p / 8 == 1) ? T_TYPE : T_CAP;
            return int'(b[7 - p % 8]);
        end
        if (op == 8'h90 && !slp && k >= 32) begin
            p = (k - 32) % 16;
            if (p / 8 == 0) b = swp ? T_DEV : T_MFR;
            else            b = swp ? T_MFR : T_DEV;
            return int'(b[7 - p % 8]);
        end
        if (op == 8'hAB && k >= 32) begin
            p = (k - 32) % 8;
            return int'(T_SIG[7 - p]);
        end
        return 2;
    endfunction

    function automatic logic in_bit(input logic [7:0] op, input logic [7:0] adr, input int k);
        if (k < 8)                return op[7 - k];
        if (k >= 24 && k < 32)    return adr[31 - k];
        return logic'((k % 3) == 0);
    endfunction

    task automatic xfer(input logic [7:0] op, input logic [7:0] adr, input int nbits,
                        input bit mode3, input string req);
        bit slp;
        int e;
        slp = asleep_m;
        @(negedge clk);
        sck = mode3;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            sck  = 1'b0;
            mosi = in_bit(op, adr, k);
            repeat (HALF) @(negedge clk);
            e = exp_slot(op, k, adr[0], slp);
            if (e == 2)
                chk(miso_oe == 1'b0, req, $sformatf("oe slot %0d", k), int'(miso_oe), 0);
            else
                chk(miso_oe == 1'b1 && miso == e[0], req,
                    $sformatf("data slot %0d (oe=%0d)", k, miso_oe), int'(miso), e);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            if (k == 7 && op == 8'hAB) begin
                asleep_m = 1'b0;
                chk(asleep == 1'b0, "R10", "asleep after wake opcode", int'(asleep), 0);
            end
        end
        if (!mode3) begin
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        if (op == 8'hB9 && nbits == 8) asleep_m = 1'b1;
        repeat (6) @(negedge clk);
        chk(miso_oe == 1'b0, "R5", "oe after deselect", int'(miso_oe), 0);
        chk(asleep == asleep_m, "R8", "asleep flag", int'(asleep), int'(asleep_m));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(miso_oe == 1'b0, "R1", "oe after reset", int'(miso_oe), 0);
        chk(asleep == 1'b0, "R1", "asleep after reset", int'(asleep), 0);

        xfer(8'h9F, 8'h00, 61, 1'b0, "R2");          // repeat after 24 slots
        xfer(8'h9F, 8'h00, 32, 1'b1, "R6");          // mode 3
        xfer(8'h90, 8'h00, 64, 1'b0, "R3");          // mfr first
        xfer(8'h90, 8'h01, 64, 1'b1, "R3");          // dev first, mode 3
        xfer(8'hAB, 8'h00, 48, 1'b0, "R4");
        xfer(8'h03, 8'h00, 40, 1'b0, "R5");          // unknown opcode
        xfer(8'h9F, 8'h00, 20, 1'b0, "R7");          // aborted mid-byte
        xfer(8'h9F, 8'h00, 34, 1'b1, "R7");          // fresh start
        xfer(8'hB9, 8'h00, 12, 1'b0, "R8");          // too long: no sleep
        xfer(8'hB9, 8'h00, 8,  1'b1, "R8");          // sleep
        xfer(8'h9F, 8'h00, 40, 1'b0, "R9");          // ignored while asleep
        xfer(8'h90, 8'h01, 48, 1'b1, "R9");
        xfer(8'hAB, 8'h00, 8,  1'b0, "R10");         // wake with opcode only
        xfer(8'h9F, 8'h00, 32, 1'b0, "R9");          // answered again
        xfer(8'hB9, 8'h00, 8,  1'b0, "R8");
        xfer(8'hAB, 8'h00, 40, 1'b1, "R4");          // signature while asleep

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule